// File: doc/BRIEF.md
# General-Purpose I/O Port with Pin-Change Wake

This block is the I/O port register set of a small microcontroller core. It holds six pad pins and two extra bit lanes that carry the clock and data lines of a serial memory peripheral. The core writes an output latch and a write-only direction register over a simple strobe bus. Port reads return the levels seen on the pads after a two-flop synchronizer. The output latch value is never returned. The block also produces the per-pad pull-up enables and a sticky wake request.

Each pad's output enable comes from its direction bit, with two exceptions. Bit 3 is input-only. The driver on bit 2 can be forced off when that pin serves as the timer clock input. Pins used for an alternate function read back as 0.

Three pins are monitored: bits 0, 1 and 3. Pull-up and change-wake each have one active-low enable that covers the whole group. The wake detector compares the synchronized levels of the monitored pins with a snapshot taken at the last port read. When bit 3 serves as the master reset input, its pull-up is forced on and it is left out of change detection.

Top module: `gpio_wake_port`

## Requirements
- R1: On either reset (rst_n or por_n low), every direction bit becomes 1, so pad_oe[5:0] reads 6'b000000 once the reset is released.
- R2: A wr_dir strobe loads wr_data[5:0] into the direction register. Each bit written 0 drives that pad with pad_oe[i]=1 and pad_out[i] equal to output latch bit i. Bits 2 and 3 follow their own rules (R3, R4).
- R3: Bit 3 is input-only. pad_oe[3] is always 0, whatever its direction bit holds.
- R4: While t0_pin_sel is 1, pad_oe[2] is 0 regardless of direction bit 2.
- R5: A wr_port strobe loads wr_data[5:0] into the output latch, which drives pad_out[5:0]. The latch keeps its value across direction writes and across rst_n. Only por_n clears it, to 0.
- R6: A rd_port strobe captures the read value into rd_data at that clock edge. Bits 5:0 come from the pad input levels after two synchronizer flops, not from the latch. A pad driven high but held low externally reads 0.
- R7: A pad whose alt_mask bit is 1 reads as 0 in rd_data.
- R8: pad_out[7:6] and pad_oe[7:6] follow sm_out and sm_oe. wr_data[7:6] has no effect on the pads. rd_data[7:6] returns the synchronized levels of pad_in[7:6].
- R9: pu_en is 6'b001011 when opt_npu is 0 and 6'b000000 when it is 1. While mclr_sel is 1, pu_en[3] is forced to 1.
- R10: While opt_nwake is 0 and at least one port read has happened since the last reset, a synchronized level of bit 0, 1 or 3 that differs from the snapshot taken at the last read sets wake_flag. Changes on bits 2, 4 and 5 never set it, and nothing sets it while opt_nwake is 1.
- R11: While mclr_sel is 1, bit 3 is excluded from change detection.
- R12: wake_flag is sticky. It stays 1 through rst_n pulses and is cleared only by por_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low general reset |
| por_n | input | 1 | Active-low power-on reset |
| wr_data | input | 8 | Write data bus |
| wr_port | input | 1 | Output latch write strobe |
| wr_dir | input | 1 | Direction register write strobe |
| rd_port | input | 1 | Port read strobe |
| rd_data | output | 8 | Captured port read value |
| opt_npu | input | 1 | Group pull-up enable, active low |
| opt_nwake | input | 1 | Group change-wake enable, active low |
| mclr_sel | input | 1 | Bit 3 serves as master reset input |
| t0_pin_sel | input | 1 | Bit 2 serves as timer clock input |
| alt_mask | input | 6 | Pins in alternate function (read as 0) |
| sm_out | input | 2 | Serial memory drive values for bits 7:6 |
| sm_oe | input | 2 | Serial memory drive enables for bits 7:6 |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pu_en | output | 6 | Per-pad weak pull-up enables |
| wake_flag | output | 1 | Sticky wake request |

## Verification
The bench holds a pad low while its latch drives it high. A design that reads the latch instead of the pad would return 1 there. It toggles pins outside the monitored group and the master-reset pin. A detector with the wrong mask would raise wake on those changes. It toggles a monitored pin before any read. A detector without the snapshot-valid gate would wake straight after reset. It pulses rst_n with a direction and a latch value set. A design that reset the wrong register would lose the latch, keep driving, or drop wake_flag.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
  localparam int unsigned PIN_W = 6;
  localparam int unsigned BUS_W = 8;
  localparam int unsigned SM_W  = BUS_W - PIN_W;
  localparam int unsigned IDX_IN_ONLY = 3;
  localparam int unsigned IDX_T0      = 2;
  localparam logic [PIN_W-1:0] WAKE_GRP = 6'b001011;

  // driver enables from direction bits and pin overrides
  function automatic logic [PIN_W-1:0] pin_oe(input logic [PIN_W-1:0] dir,
                                              input logic t0_sel);
    logic [PIN_W-1:0] oe;
    oe = ~dir;
    oe[IDX_IN_ONLY] = 1'b0;
    if (t0_sel) oe[IDX_T0] = 1'b0;
    return oe;
  endfunction

  // group pull-up with reset-pin override
  function automatic logic [PIN_W-1:0] pull_en(input logic npu, input logic mclr);
    logic [PIN_W-1:0] pe;
    pe = npu ? '0 : WAKE_GRP;
    if (mclr) pe[IDX_IN_ONLY] = 1'b1;
    return pe;
  endfunction

  // pins watched by the change detector
  function automatic logic [PIN_W-1:0] wake_mask(input logic mclr);
    logic [PIN_W-1:0] m;
    m = WAKE_GRP;
    if (mclr) m[IDX_IN_ONLY] = 1'b0;
    return m;
  endfunction

  function automatic logic [BUS_W-1:0] read_val(input logic [BUS_W-1:0] lvl,
                                               input logic [PIN_W-1:0] alt);
    return {lvl[BUS_W-1:PIN_W], lvl[PIN_W-1:0] & ~alt};
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_wake_pkg::*;
(
  input  logic             clk,
  input  logic             any_rst_n,
  input  logic             por_n,
  input  logic [PIN_W-1:0] wr_pins,
  input  logic             wr_port,
  input  logic             wr_dir,
  input  logic             t0_sel,
  input  logic             mclr_sel,
  input  logic             opt_npu,
  output logic [PIN_W-1:0] latch_q,
  output logic [PIN_W-1:0] oe,
  output logic [PIN_W-1:0] pu
);
  logic [PIN_W-1:0] dir_q;

  // latch survives general reset, cleared at power-on only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) latch_q <= '0;
    else if (wr_port) latch_q <= wr_pins;
  end

  always_ff @(posedge clk or negedge any_rst_n) begin
    if (!any_rst_n) dir_q <= '1;
    else if (wr_dir) dir_q <= wr_pins;
  end

  assign oe = pin_oe(dir_q, t0_sel);
  assign pu = pull_en(opt_npu, mclr_sel);
endmodule

// File: rtl/gpio_wake_det.sv
module gpio_wake_det
  import gpio_wake_pkg::*;
(
  input  logic             clk,
  input  logic             any_rst_n,
  input  logic             por_n,
  input  logic [PIN_W-1:0] lvl,
  input  logic             rd_port,
  input  logic             opt_nwake,
  input  logic             mclr_sel,
  output logic             wake_hit,
  output logic             snap_valid,
  output logic             wake_flag
);
  logic [PIN_W-1:0] snap_q;
  logic [PIN_W-1:0] diff;

  always_ff @(posedge clk or negedge any_rst_n) begin
    if (!any_rst_n) begin
      snap_q     <= '0;
      snap_valid <= 1'b0;
    end else if (rd_port) begin
      snap_q     <= lvl & WAKE_GRP;
      snap_valid <= 1'b1;
    end
  end

  assign diff     = (lvl ^ snap_q) & wake_mask(mclr_sel);
  assign wake_hit = snap_valid & ~opt_nwake & (|diff);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) wake_flag <= 1'b0;
    else if (wake_hit) wake_flag <= 1'b1;
  end
endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port
  import gpio_wake_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             wr_port,
  input  logic             wr_dir,
  input  logic             rd_port,
  output logic [BUS_W-1:0] rd_data,
  input  logic             opt_npu,
  input  logic             opt_nwake,
  input  logic             mclr_sel,
  input  logic             t0_pin_sel,
  input  logic [PIN_W-1:0] alt_mask,
  input  logic [SM_W-1:0]  sm_out,
  input  logic [SM_W-1:0]  sm_oe,
  input  logic [BUS_W-1:0] pad_in,
  output logic [BUS_W-1:0] pad_out,
  output logic [BUS_W-1:0] pad_oe,
  output logic [PIN_W-1:0] pu_en,
  output logic             wake_flag
);
  logic             any_rst_n;
  logic [BUS_W-1:0] lvl_sync;
  logic [PIN_W-1:0] latch_q;
  logic [PIN_W-1:0] pin_oe_w;
  logic             wake_hit;
  logic             snap_valid;

  assign any_rst_n = rst_n & por_n;

  gpio_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(any_rst_n), .d(pad_in), .q(lvl_sync)
  );

  gpio_pin_ctrl u_pins (
    .clk(clk), .any_rst_n(any_rst_n), .por_n(por_n),
    .wr_pins(wr_data[PIN_W-1:0]), .wr_port(wr_port), .wr_dir(wr_dir),
    .t0_sel(t0_pin_sel), .mclr_sel(mclr_sel), .opt_npu(opt_npu),
    .latch_q(latch_q), .oe(pin_oe_w), .pu(pu_en)
  );

  gpio_wake_det u_wake (
    .clk(clk), .any_rst_n(any_rst_n), .por_n(por_n),
    .lvl(lvl_sync[PIN_W-1:0]), .rd_port(rd_port),
    .opt_nwake(opt_nwake), .mclr_sel(mclr_sel),
    .wake_hit(wake_hit), .snap_valid(snap_valid), .wake_flag(wake_flag)
  );

  always_ff @(posedge clk or negedge any_rst_n) begin
    if (!any_rst_n) rd_data <= '0;
    else if (rd_port) rd_data <= read_val(lvl_sync, alt_mask);
  end

  assign pad_out = {sm_out, latch_q};
  assign pad_oe  = {sm_oe, pin_oe_w};
endmodule

// File: rtl/gpio_wake_port_chk.sv
module gpio_wake_port_chk
  import gpio_wake_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             por_n,
  input logic             opt_nwake,
  input logic             mclr_sel,
  input logic             t0_pin_sel,
  input logic [BUS_W-1:0] pad_oe,
  input logic [PIN_W-1:0] pu_en,
  input logic             wake_flag,
  input logic             wake_hit,
  input logic             snap_valid
);
  assert_dir_reset_R1: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(rst_n) |-> (pad_oe[PIN_W-1:0] == '0));

  assert_gp3_input_only_R3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    pad_oe[IDX_IN_ONLY] == 1'b0);

  assert_t0_override_R4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    t0_pin_sel |-> !pad_oe[IDX_T0]);

  assert_pullup_group_R9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (pu_en[5:4] == 2'b00) && !pu_en[2] && (!mclr_sel || pu_en[3]));

  assert_wake_cause_R10: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(wake_flag) |-> $past(wake_hit && snap_valid && !opt_nwake));

  assert_wake_off_R10: assert property (@(posedge clk) disable iff (!por_n)
    (!wake_flag && opt_nwake) |=> !wake_flag);

  assert_wake_sticky_R12: assert property (@(posedge clk) disable iff (!por_n)
    wake_flag |=> wake_flag);
endmodule

bind gpio_wake_port gpio_wake_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .opt_nwake(opt_nwake),
  .mclr_sel(mclr_sel), .t0_pin_sel(t0_pin_sel), .pad_oe(pad_oe),
  .pu_en(pu_en), .wake_flag(wake_flag), .wake_hit(wake_hit),
  .snap_valid(snap_valid)
);

// File: tb/test_gpio_wake_port.sv
`timescale 1ns/1ps
module test_gpio_wake_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_port = 0, wr_dir = 0, rd_port = 0;
  logic [7:0] rd_data;
  logic opt_npu = 1, opt_nwake = 1, mclr_sel = 0, t0_pin_sel = 0;
  logic [5:0] alt_mask = '0;
  logic [1:0] sm_out = '0, sm_oe = '0;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe;
  logic [5:0] pu_en;
  logic wake_flag;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_wake_port i_gpio_wake_port (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit dir, input logic [7:0] v);
    @(negedge clk); wr_data = v; wr_port = !dir; wr_dir = dir;
    @(negedge clk); wr_port = 0; wr_dir = 0;
  endtask

  task automatic rd();
    @(negedge clk); rd_port = 1;
    @(negedge clk); rd_port = 0;
  endtask

  task automatic pulse_rst(input bit por);
    @(negedge clk); if (por) por_n = 0; else rst_n = 0;
    cyc(2); por_n = 1; rst_n = 1; cyc(1);
  endtask

  task automatic t_reset();
    check("R1 oe after reset", {2'b0, pad_oe[5:0]}, 8'h00);
    check("R12 wake after por", {7'b0, wake_flag}, 8'h00);
    check("R9 pullups off", {2'b0, pu_en}, 8'h00);
  endtask

  task automatic t_drive();
    wr(0, 8'hEA);
    wr(1, 8'h00);
    check("R2 oe all out", {2'b0, pad_oe[5:0]}, 8'h37);
    check("R5 latch on pads", {2'b0, pad_out[5:0]}, 8'h2A);
    check("R3 gp3 oe off", {7'b0, pad_oe[3]}, 8'h00);
    t0_pin_sel = 1; cyc(1);
    check("R4 gp2 override", {2'b0, pad_oe[5:0]}, 8'h33);
    t0_pin_sel = 0;
    wr(1, 8'h3F);
    check("R5 latch kept dir in", {2'b0, pad_out[5:0]}, 8'h2A);
    wr(1, 8'h00);
    pulse_rst(0);
    check("R1 rst_n sets dir", {2'b0, pad_oe[5:0]}, 8'h00);
    check("R5 latch kept rst_n", {2'b0, pad_out[5:0]}, 8'h2A);
  endtask

  task automatic t_read();
    wr(0, 8'h01); wr(1, 8'h3E);
    pad_in = 8'hC4; cyc(3); rd();
    check("R6 pin not latch", rd_data, 8'hC4);
    pad_in = 8'h3B; cyc(3); rd();
    check("R6 pin levels", rd_data, 8'h3B);
    alt_mask = 6'b000101; rd();
    check("R7 alt reads 0", rd_data, 8'h3A);
    alt_mask = '0;
  endtask

  task automatic t_sm();
    sm_out = 2'b10; sm_oe = 2'b01;
    wr(0, 8'h40); cyc(1);
    check("R8 sm out", {6'b0, pad_out[7:6]}, 8'h02);
    check("R8 sm oe", {6'b0, pad_oe[7:6]}, 8'h01);
    pad_in = 8'h80; cyc(3); rd();
    check("R8 sm read", rd_data, 8'h80);
    sm_out = 0; sm_oe = 0;
  endtask

  task automatic t_pull();
    opt_npu = 0; cyc(1);
    check("R9 group pullups", {2'b0, pu_en}, 8'h0B);
    opt_npu = 1; mclr_sel = 1; cyc(1);
    check("R9 mclr pullup", {2'b0, pu_en}, 8'h08);
    mclr_sel = 0;
  endtask

  task automatic t_wake();
    pad_in = 8'h00; pulse_rst(1);
    opt_nwake = 0;
    pad_in = 8'h01; cyc(4);
    check("R10 no snapshot", {7'b0, wake_flag}, 8'h00);
    rd();
    pad_in = 8'h35; cyc(4);
    check("R10 unmonitored pins", {7'b0, wake_flag}, 8'h00);
    pad_in = 8'h37; cyc(4);
    check("R10 gp1 change", {7'b0, wake_flag}, 8'h01);
    pulse_rst(0);
    check("R12 kept over rst_n", {7'b0, wake_flag}, 8'h01);
    pulse_rst(1);
    check("R12 cleared by por", {7'b0, wake_flag}, 8'h00);
    opt_nwake = 1; cyc(3); rd();
    pad_in = 8'h36; cyc(4);
    check("R10 disabled", {7'b0, wake_flag}, 8'h00);
    mclr_sel = 1; rd(); opt_nwake = 0;
    pad_in = 8'h3E; cyc(4);
    check("R11 gp3 excluded", {7'b0, wake_flag}, 8'h00);
    pad_in = 8'h3F; cyc(4);
    check("R11 gp0 still wakes", {7'b0, wake_flag}, 8'h01);
    mclr_sel = 0; opt_nwake = 1;
  endtask

  initial begin
    cyc(3); por_n = 1; rst_n = 1; cyc(2);
    t_reset();
    t_drive();
    t_read();
    t_sm();
    t_pull();
    t_wake();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule